// File: doc/BRIEF.md
# Configuration-Exchange Auto-Negotiation Controller

This block runs the base-page configuration exchange of a gigabit fibre link against its partner. It starts when the physical layer reports link synchronization and the negotiation enable bit is set. It moves through a fixed series of phases. First it sends zero configuration words while a programmable timer runs. Next it sends the local ability word without acknowledge, and then with acknowledge. After that it keeps sending for one more timer interval. Finally it switches to idles and waits for the partner to go quiet. The block sees receive traffic only as already-decoded events. Each event is either a configuration ordered set with its 16-bit word or an idle ordered set. On the transmit side it asks the encoder for either configuration sets carrying a 16-bit word or idles.

The state machine has seven named states. OFF sends idles and holds until sync and enable are both present. RESTART sends word 0x0000 and leaves on timer expiry. ABILITY sends the local word with bit 14 clear and leaves after three matching partner words. ACK sends the local word with bit 14 set and leaves after three matching acknowledged words. LINGER keeps sending the acknowledged word and leaves on timer expiry. IDLE_WAIT sends idles and leaves after three consecutive idles. DONE raises the completion flag and goes back to RESTART on an all-zero configuration word. From any state, a loss of sync or a cleared enable returns the block to OFF. The partner word captured at the end of ABILITY stays available to software, which does the priority resolution.

Top module: `cfg_exchange_ctrl`

## Requirements
- R1: After reset the block requests idles (tx_send_cfg = 0), an_done is 0 and partner_ability is 0x0000.
- R2: While link_ok or an_enable is 0, the block requests idles and an_done is 0. Dropping either input returns the block to OFF on the next clock edge. This takes priority over any match that is completing in the same cycle.
- R3: When link_ok and an_enable are both 1 in OFF, the block sends configuration sets with word 0x0000 for exactly timer_limit+1 cycles. The limit is read from the timer_limit input.
- R4: After the first timer interval, the advertised word equals local_ability with bit 14 (the acknowledge bit) forced to 0.
- R5: In ABILITY, three consecutive configuration events whose words are equal when bit 14 is ignored move the block to ACK one cycle after the third event. partner_ability then takes the last matched word. An idle event or a differing word restarts the run. A cycle with rx_evt_valid = 0 does not break the run.
- R6: In ACK, the advertised word is local_ability with bit 14 set to 1. Only three consecutive identical words that have bit 14 set complete this phase. A word with bit 14 clear resets the run.
- R7: After the acknowledged match, the block keeps sending the acknowledged word for timer_limit+1 more cycles after the move into LINGER, and then requests idles.
- R8: an_done rises one cycle after the third consecutive idle event received after that second timer expiry. A configuration event in between resets the idle run.
- R9: In DONE, a configuration event with word 0x0000 clears an_done on the next edge and restarts the exchange from RESTART.
- R10: partner_ability changes only at the ABILITY-to-ACK transition. It holds its value through every other phase and through restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| link_ok | input | 1 | Link synchronization reported by the receiver |
| an_enable | input | 1 | Negotiation enable |
| rx_evt_valid | input | 1 | A decoded receive ordered set is presented this cycle |
| rx_is_cfg | input | 1 | 1: the event is a configuration set; 0: it is an idle |
| rx_word | input | 16 | Configuration word carried by the event |
| timer_limit | input | TMR_W | Link-timer terminal count |
| local_ability | input | 16 | Local ability word to advertise |
| tx_send_cfg | output | 1 | 1: send configuration sets; 0: send idles |
| tx_word | output | 16 | Configuration word to send |
| partner_ability | output | 16 | Captured partner ability word |
| an_done | output | 1 | Negotiation complete |

## Verification
Two things can land in the same cycle: the third matching partner word that would end ABILITY, and a loss of link synchronization. The bench provokes this by giving the third matching word in the same cycle that link_ok falls. The word it gives differs from the one captured earlier. The result is judged correct when the next cycle shows idles requested and partner_ability unchanged. After link_ok returns, the exchange must start again with word 0x0000 and not with the acknowledged word.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;

    typedef enum logic [2:0] {
        ST_OFF       = 3'd0,
        ST_RESTART   = 3'd1,
        ST_ABILITY   = 3'd2,
        ST_ACK       = 3'd3,
        ST_LINGER    = 3'd4,
        ST_IDLE_WAIT = 3'd5,
        ST_DONE      = 3'd6
    } cfgx_state_t;

endpackage

// File: rtl/cfgx_link_timer.sv
module cfgx_link_timer #(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] limit,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;
    logic             run_q;

    // Counts up from zero after start and parks at the limit.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (start) begin
            cnt_q <= '0;
            run_q <= 1'b1;
        end else if (run_q && (cnt_q < limit)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired = run_q && (cnt_q >= limit);

    // R3: a fresh start always clears expiry on the next cycle
    p_start_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (start && (limit != '0)) |=> !expired);

endmodule

// File: rtl/cfgx_word_matcher.sv
module cfgx_word_matcher #(
    parameter int WORD_W  = 16,
    parameter int ACK_POS = 14,
    parameter int RUN_N   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              ev_valid,
    input  logic              ev_cfg,
    input  logic [WORD_W-1:0] ev_word,
    input  logic              ignore_ack,
    input  logic              need_ack,
    output logic              hit,
    output logic [WORD_W-1:0] held_word
);
    localparam int RUN_W = $clog2(RUN_N + 1);
    localparam logic [WORD_W-1:0] ACK_MASK = {{(WORD_W-1){1'b0}}, 1'b1} << ACK_POS;
    localparam logic [RUN_W-1:0]  RUN_TOP  = RUN_W'(RUN_N);

    logic [RUN_W-1:0]  run_q;
    logic [WORD_W-1:0] word_q;
    logic [WORD_W-1:0] cmp_mask;
    logic              same;
    logic              qualified;

    always_comb begin
        cmp_mask  = ignore_ack ? ~ACK_MASK : '1;
        same      = (((ev_word ^ word_q) & cmp_mask) == '0);
        qualified = ev_cfg && (!need_ack || ((ev_word & ACK_MASK) != '0));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q  <= '0;
            word_q <= '0;
        end else if (clear) begin
            run_q <= '0;
        end else if (ev_valid) begin
            if (!qualified) begin
                run_q <= '0;
            end else begin
                word_q <= ev_word;
                if ((run_q != '0) && same) begin
                    if (run_q != RUN_TOP) run_q <= run_q + 1'b1;
                end else begin
                    run_q <= {{(RUN_W-1){1'b0}}, 1'b1};
                end
            end
        end
    end

    assign hit       = (run_q == RUN_TOP);
    assign held_word = word_q;

    // R5: a run can only complete on a received configuration event
    p_hit_on_cfg_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hit) |-> $past(ev_valid && ev_cfg));

    // R6: with acknowledge demanded, a completed run holds an acknowledged word
    p_ack_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(hit) && $past(need_ack)) |-> ((held_word & ACK_MASK) != '0));

endmodule

// File: rtl/cfgx_idle_run.sv
module cfgx_idle_run #(
    parameter int RUN_N = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic ev_valid,
    input  logic ev_cfg,
    output logic hit
);
    localparam int RUN_W = $clog2(RUN_N + 1);
    localparam logic [RUN_W-1:0] RUN_TOP = RUN_W'(RUN_N);

    logic [RUN_W-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (clear) begin
            run_q <= '0;
        end else if (ev_valid) begin
            if (ev_cfg)                run_q <= '0;
            else if (run_q != RUN_TOP) run_q <= run_q + 1'b1;
        end
    end

    assign hit = (run_q == RUN_TOP);

    // R8: the idle run completes only on an idle event
    p_idle_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hit) |-> $past(ev_valid && !ev_cfg));

endmodule

// File: rtl/cfg_exchange_ctrl.sv
module cfg_exchange_ctrl
    import cfgx_pkg::*;
#(
    parameter int WORD_W  = 16,
    parameter int ACK_POS = 14,
    parameter int RUN_N   = 3,
    parameter int TMR_W   = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              link_ok,
    input  logic              an_enable,
    input  logic              rx_evt_valid,
    input  logic              rx_is_cfg,
    input  logic [WORD_W-1:0] rx_word,
    input  logic [TMR_W-1:0]  timer_limit,
    input  logic [WORD_W-1:0] local_ability,
    output logic              tx_send_cfg,
    output logic [WORD_W-1:0] tx_word,
    output logic [WORD_W-1:0] partner_ability,
    output logic              an_done
);
    localparam logic [WORD_W-1:0] ACK_MASK = {{(WORD_W-1){1'b0}}, 1'b1} << ACK_POS;

    cfgx_state_t       state_q, state_d;
    logic              go;
    logic              leave;
    logic              tmr_start, tmr_expired;
    logic              m_hit;
    logic [WORD_W-1:0] m_word;
    logic              idle_hit;
    logic              zero_cfg;
    logic [WORD_W-1:0] partner_q;

    assign go       = link_ok && an_enable;
    assign zero_cfg = rx_evt_valid && rx_is_cfg && (rx_word == '0);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (!go) begin
            state_d = ST_OFF;
        end else begin
            unique case (state_q)
                ST_OFF:       state_d = ST_RESTART;
                ST_RESTART:   if (tmr_expired) state_d = ST_ABILITY;
                ST_ABILITY:   if (m_hit)       state_d = ST_ACK;
                ST_ACK:       if (m_hit)       state_d = ST_LINGER;
                ST_LINGER:    if (tmr_expired) state_d = ST_IDLE_WAIT;
                ST_IDLE_WAIT: if (idle_hit)    state_d = ST_DONE;
                ST_DONE:      if (zero_cfg)    state_d = ST_RESTART;
                default:      state_d = ST_OFF;
            endcase
        end
    end

    assign leave     = (state_d != state_q);
    assign tmr_start = leave && ((state_d == ST_RESTART) || (state_d == ST_LINGER));

    // State register and partner capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_OFF;
            partner_q <= '0;
        end else begin
            state_q <= state_d;
            if ((state_q == ST_ABILITY) && (state_d == ST_ACK))
                partner_q <= m_word;
        end
    end

    // Outputs decoded from the state
    always_comb begin
        tx_send_cfg = 1'b0;
        tx_word     = '0;
        an_done     = 1'b0;
        unique case (state_q)
            ST_RESTART: begin
                tx_send_cfg = 1'b1;
                tx_word     = '0;
            end
            ST_ABILITY: begin
                tx_send_cfg = 1'b1;
                tx_word     = local_ability & ~ACK_MASK;
            end
            ST_ACK, ST_LINGER: begin
                tx_send_cfg = 1'b1;
                tx_word     = local_ability | ACK_MASK;
            end
            ST_DONE:  an_done = 1'b1;
            default:  tx_send_cfg = 1'b0;
        endcase
    end

    assign partner_ability = partner_q;

    cfgx_link_timer #(
        .CNT_W (TMR_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (tmr_start),
        .limit   (timer_limit),
        .expired (tmr_expired)
    );

    cfgx_word_matcher #(
        .WORD_W  (WORD_W),
        .ACK_POS (ACK_POS),
        .RUN_N   (RUN_N)
    ) u_match (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (leave),
        .ev_valid   (rx_evt_valid),
        .ev_cfg     (rx_is_cfg),
        .ev_word    (rx_word),
        .ignore_ack (state_q == ST_ABILITY),
        .need_ack   (state_q == ST_ACK),
        .hit        (m_hit),
        .held_word  (m_word)
    );

    cfgx_idle_run #(
        .RUN_N (RUN_N)
    ) u_idle (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (leave),
        .ev_valid (rx_evt_valid && (state_q == ST_IDLE_WAIT)),
        .ev_cfg   (rx_is_cfg),
        .hit      (idle_hit)
    );

    // R2: losing sync or enable forces idles on the next cycle
    p_off_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !go |=> (!tx_send_cfg && !an_done));

    // R3: the zero-word phase is held until the timer reports expiry
    p_restart_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_RESTART) && !tmr_expired && go) |=> (state_q == ST_RESTART));

    // R5: entering the acknowledge phase needs a completed match
    p_ack_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == ST_ACK) |-> $past(m_hit));

    // R8: completion follows a completed idle run
    p_done_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(an_done) |-> $past(idle_hit));

    // R9: a zero word after completion restarts with zero advertised
    p_zero_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (an_done && zero_cfg && go) |=> (tx_send_cfg && (tx_word == '0) && !an_done));

    // R10: the captured word moves only when leaving ABILITY
    p_partner_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_ABILITY) |=> $stable(partner_ability));

endmodule

// File: tb/cfg_exchange_ctrl_bench.sv
module cfg_exchange_ctrl_bench;
    localparam int PERIOD = 10;
    localparam int TW     = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          link_ok = 1'b0;
    logic          an_enable = 1'b0;
    logic          rx_evt_valid = 1'b0;
    logic          rx_is_cfg = 1'b0;
    logic [15:0]   rx_word = '0;
    logic [TW-1:0] timer_limit = TW'(5);
    logic [15:0]   local_ability = 16'h41A0;
    logic          tx_send_cfg;
    logic [15:0]   tx_word;
    logic [15:0]   partner_ability;
    logic          an_done;

    int n_chk  = 0;
    int n_fail = 0;

    localparam logic [15:0] ACKB = 16'h4000;
    localparam logic [15:0] WA   = 16'h01E0;
    localparam logic [15:0] WB   = 16'h0020;
    localparam logic [15:0] WC   = 16'h0160;

    always #(PERIOD/2) clk = ~clk;

    cfg_exchange_ctrl u_cfg_exchange_ctrl (
        .clk             (clk),
        .rst_n           (rst_n),
        .link_ok         (link_ok),
        .an_enable       (an_enable),
        .rx_evt_valid    (rx_evt_valid),
        .rx_is_cfg       (rx_is_cfg),
        .rx_word         (rx_word),
        .timer_limit     (timer_limit),
        .local_ability   (local_ability),
        .tx_send_cfg     (tx_send_cfg),
        .tx_word         (tx_word),
        .partner_ability (partner_ability),
        .an_done         (an_done)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one event at the falling edge, sample shortly after the rising edge.
    task automatic tick(input logic v, input logic c, input logic [15:0] w);
        @(negedge clk);
        rx_evt_valid = v;
        rx_is_cfg    = c;
        rx_word      = w;
        @(posedge clk);
        #1;
    endtask

    task automatic quiet(input int n);
        for (int i = 0; i < n; i++) tick(1'b0, 1'b0, 16'h0000);
    endtask

    // Counts cycles spent advertising the zero word, starting on the current sample.
    task automatic count_zero(input int lim, input string req);
        int c;
        c = 0;
        while (tx_send_cfg && (tx_word == 16'h0000) && (c < 200)) begin
            c++;
            tick(1'b0, 1'b0, 16'h0000);
        end
        chk(c == lim + 1, req, c, lim + 1);
    endtask

    task automatic t_reset;
        chk(tx_send_cfg == 1'b0, "R1 tx_send_cfg", tx_send_cfg, 0);
        chk(an_done == 1'b0, "R1 an_done", an_done, 0);
        chk(partner_ability == 16'h0000, "R1 partner_ability", partner_ability, 0);
    endtask

    task automatic t_bringup;
        link_ok = 1'b1;
        quiet(3);
        chk(tx_send_cfg == 1'b0, "R2 idle with enable low", tx_send_cfg, 0);
        an_enable = 1'b1;
        tick(1'b0, 1'b0, 16'h0000);
        count_zero(5, "R3 zero-word duration");
        chk(tx_send_cfg && tx_word == (local_ability & ~ACKB), "R4 ability word", tx_word, local_ability & ~ACKB);
    endtask

    task automatic t_ability;
        tick(1'b1, 1'b1, WA);
        tick(1'b1, 1'b1, WA);
        tick(1'b1, 1'b1, WB);
        tick(1'b1, 1'b0, 16'h0000);
        tick(1'b1, 1'b1, WA);
        quiet(2);
        tick(1'b1, 1'b1, WA | ACKB);
        chk(tx_word[14] == 1'b0, "R5 run broken by idle/differing word", tx_word, local_ability & ~ACKB);
        tick(1'b1, 1'b1, WA);
        chk(tx_word[14] == 1'b0, "R5 no ACK on matching cycle", tx_word, local_ability & ~ACKB);
        quiet(1);
        chk(tx_send_cfg && tx_word == (local_ability | ACKB), "R6 ack word advertised", tx_word, local_ability | ACKB);
        chk(partner_ability == WA, "R5 captured partner word", partner_ability, WA);
    endtask

    task automatic t_ack_linger;
        int c;
        tick(1'b1, 1'b1, WA | ACKB);
        tick(1'b1, 1'b1, WA | ACKB);
        tick(1'b1, 1'b1, WA);
        tick(1'b1, 1'b1, WA | ACKB);
        tick(1'b1, 1'b1, WA | ACKB);
        quiet(12);
        chk(tx_send_cfg && tx_word == (local_ability | ACKB), "R6 word without ACK resets run", tx_word, local_ability | ACKB);
        tick(1'b1, 1'b1, WA | ACKB);
        c = 0;
        quiet(1);
        while (tx_send_cfg && (c < 200)) begin
            c++;
            quiet(1);
        end
        chk(c == 6, "R7 linger duration", c, 6);
        chk(!tx_send_cfg, "R7 idles after linger", tx_send_cfg, 0);
        chk(partner_ability == WA, "R10 partner held through ACK phase", partner_ability, WA);
    endtask

    task automatic t_idle_done;
        tick(1'b1, 1'b0, 16'h0000);
        tick(1'b1, 1'b0, 16'h0000);
        tick(1'b1, 1'b1, WA | ACKB);
        tick(1'b1, 1'b0, 16'h0000);
        tick(1'b1, 1'b0, 16'h0000);
        quiet(2);
        chk(an_done == 1'b0, "R8 idle run reset by cfg", an_done, 0);
        tick(1'b1, 1'b0, 16'h0000);
        chk(an_done == 1'b0, "R8 not done on third idle cycle", an_done, 0);
        quiet(1);
        chk(an_done == 1'b1, "R8 done after three idles", an_done, 1);
        chk(!tx_send_cfg, "R8 idles while done", tx_send_cfg, 0);
    endtask

    task automatic t_zero_restart;
        tick(1'b1, 1'b1, WB);
        chk(an_done == 1'b1, "R9 nonzero word keeps done", an_done, 1);
        tick(1'b1, 1'b1, 16'h0000);
        chk(an_done == 1'b0, "R9 done cleared", an_done, 0);
        chk(tx_send_cfg && tx_word == 16'h0000, "R9 restart word", tx_word, 0);
        chk(partner_ability == WA, "R10 partner kept over restart", partner_ability, WA);
    endtask

    // Third match and loss of sync land in the same cycle.
    task automatic t_race;
        int g;
        g = 0;
        while (!(tx_send_cfg && tx_word != 16'h0000) && g < 100) begin
            g++;
            quiet(1);
        end
        chk(tx_word == (local_ability & ~ACKB), "R4 ability word after restart", tx_word, local_ability & ~ACKB);
        tick(1'b1, 1'b1, WC);
        tick(1'b1, 1'b1, WC);
        link_ok = 1'b0;
        tick(1'b1, 1'b1, WC);
        chk(!tx_send_cfg, "R2 sync loss beats match", tx_send_cfg, 0);
        quiet(1);
        chk(partner_ability == WA, "R10 no capture on sync loss", partner_ability, WA);
        link_ok = 1'b1;
        quiet(1);
        chk(tx_send_cfg && tx_word == 16'h0000, "R2 relink restarts at zero word", tx_word, 0);
    endtask

    task automatic t_enable_drop;
        an_enable = 1'b0;
        quiet(1);
        chk(!tx_send_cfg && !an_done, "R2 enable drop idles", tx_send_cfg, 0);
        timer_limit = TW'(2);
        an_enable = 1'b1;
        quiet(1);
        count_zero(2, "R3 programmed limit 2");
    endtask

    initial begin
        #(PERIOD * 100000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(PERIOD * 3 + 2);
        rst_n = 1'b1;
        quiet(1);
        t_reset;
        t_bringup;
        t_ability;
        t_ack_linger;
        t_idle_done;
        t_zero_restart;
        t_race;
        t_enable_drop;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule